// File: doc/BRIEF.md
# Register History Buffer with Exception Rollback

This block lets a pipeline write its register file before an instruction is known to be safe. Every accepted register write is recorded in a small circular log as a triple: the program counter of the writing instruction, the destination register number and the value that register held before the write. When an instruction commits, its oldest log record is no longer needed and is released.

When an instruction faults, the pipeline raises an exception request carrying the faulting program counter. The block then walks the log from the newest record towards the oldest. It issues one restore write per cycle on a dedicated register-file write port, undoing every write made by the faulting instruction or by any younger one. When the walk reaches a record older than the fault, or runs out of records, the remaining older records are discarded. The register file then holds the state at the last committed point, and the faulting instruction can be re-executed.

While the walk runs, a busy flag is high and the write-side stall is asserted. The stall is also asserted whenever the log is full.

Top module: `history_rollback`

## Requirements
- R1: A write with `wr_en` high, `wr_stall` low, no exception accepted in the same cycle and a non-zero `wr_reg` appends one record holding `wr_pc`, `wr_reg` and `wr_old`.
- R2: A write to register number 0 appends no record.
- R3: `wr_stall` is high while the log holds DEPTH records (default 16), and a write offered while `wr_stall` is high appends no record.
- R4: `commit_en` releases the oldest record. A commit on an empty log, during a rollback, or in a cycle where an exception is accepted has no effect.
- R5: An `exc_req` seen while `rb_busy` is low is accepted, and `rb_busy` is high from the following cycle.
- R6: During rollback, records are restored newest first, one per cycle. Each restore drives `rst_we` high with the record's register number on `rst_reg` and its old value on `rst_val`.
- R7: Only records whose PC is greater than or equal to the faulting PC (unsigned comparison) are restored. All records older than that are discarded, so the log is empty when rollback ends.
- R8: With N qualifying records, `rb_busy` stays high for exactly N+1 cycles. The last of these cycles has `rst_we` low.
- R9: While `rb_busy` is high, `wr_stall` is high, and writes, commits and further exception requests are ignored.
- R10: In the cycle an exception is accepted, a write or commit offered at the same time is ignored.
- R11: After reset, `rb_busy`, `wr_stall` and `rst_we` are low and the log is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register-file write taking place |
| wr_pc | input | PC_W | PC of the writing instruction |
| wr_reg | input | log2(REG_N) | Destination register number |
| wr_old | input | XLEN | Value being overwritten |
| wr_stall | output | 1 | Log full or rollback in progress; hold writes |
| commit_en | input | 1 | Oldest outstanding instruction commits |
| exc_req | input | 1 | Exception request |
| exc_pc | input | PC_W | PC of the faulting instruction |
| rb_busy | output | 1 | Rollback walk in progress |
| rst_we | output | 1 | Restore write enable |
| rst_reg | output | log2(REG_N) | Restore register number |
| rst_val | output | XLEN | Restore value |

## Verification
The hardest state to reach from the ports is a rollback that stops part-way through the log. This needs a log with known contents, where the fault PC falls strictly between two recorded PCs, so that some records are restored and the rest are silently discarded. The bench fills the log with strictly increasing PCs and sweeps the fault position across every record and past the newest. A follow-up exception then proves the discarded records are gone. Separate sequences drive writes, commits and exceptions into the busy window and into the accepting cycle, and fill the log past full behind an earlier commit.

// File: rtl/hb_pkg.sv
// Package: shared types for the register history buffer.
// Assumes nothing beyond being compiled before the modules that import it.
package hb_pkg;
    typedef enum logic {
        RB_IDLE = 1'b0,
        RB_WALK = 1'b1
    } rb_state_e;
endpackage

// File: rtl/hb_log_ring.sv
// Circular log of packed records. New records enter at the tail. Commit
// removes the oldest record at the head. Rollback removes the newest record
// at the tail. Clear empties the log in one cycle.
// Assumes: the caller never pushes when full, never pops when empty, and
// never combines pop_new or clear with any other operation.
module hb_log_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 69
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop_old,
    input  logic                       pop_new,
    input  logic                       clear,
    output logic [W-1:0]               newest,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] head, tail;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH-1) : p - 1'b1;
    endfunction

    // Record storage: write the new record at the tail slot.
    always_ff @(posedge clk) begin
        if (push) mem[tail] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push)    tail <= ptr_inc(tail);
            if (pop_new) tail <= ptr_dec(tail);
            if (pop_old) head <= ptr_inc(head);
            count <= count + CNT_W'(push) - CNT_W'(pop_old) - CNT_W'(pop_new);
        end
    end

    // Status and newest-record view.
    always_comb begin
        full   = (count == CNT_W'(DEPTH));
        empty  = (count == '0);
        newest = mem[ptr_dec(tail)];
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_old || pop_new) |-> !empty);
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    p_pop_new_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_new && !clear) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/hb_rollback_ctrl.sv
// Rollback sequencer. An accepted exception latches the faulting PC. Each
// cycle after that, the newest log record is either restored (its PC is at or
// after the fault) or the walk ends and the whole log is cleared.
// Assumes: PCs in the log increase from oldest to newest.
module hb_rollback_ctrl
    import hb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_req,
    input  logic [PC_W-1:0] exc_pc,
    input  logic            log_empty,
    input  logic [PC_W-1:0] newest_pc,
    output logic            busy,
    output logic            restore_fire,
    output logic            drop_all
);
    rb_state_e       state;
    logic [PC_W-1:0] fault_pc;

    // Decide restore or finish for the current walk cycle.
    always_comb begin
        busy         = (state == RB_WALK);
        restore_fire = busy && !log_empty && (newest_pc >= fault_pc);
        drop_all     = busy && !restore_fire;
    end

    // Walk state and latched fault PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RB_IDLE;
            fault_pc <= '0;
        end else begin
            case (state)
                RB_IDLE: if (exc_req) begin
                    state    <= RB_WALK;
                    fault_pc <= exc_pc;
                end
                RB_WALK: if (drop_all) state <= RB_IDLE;
                default: state <= RB_IDLE;
            endcase
        end
    end

    p_restore_in_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restore_fire |-> (busy && !log_empty));
    p_walk_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop_all |=> !busy);
endmodule

// File: rtl/history_rollback.sv
// Register history buffer top. Logs overwritten register values, frees them
// on commit, and replays them newest first on an exception.
// Assumes: the pipeline holds writes while wr_stall is high, commits in
// program order, and issues register writes in increasing PC order.
module history_rollback #(
    parameter int XLEN  = 32,
    parameter int PC_W  = 32,
    parameter int REG_N = 32,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [PC_W-1:0]          wr_pc,
    input  logic [$clog2(REG_N)-1:0] wr_reg,
    input  logic [XLEN-1:0]          wr_old,
    output logic                     wr_stall,
    input  logic                     commit_en,
    input  logic                     exc_req,
    input  logic [PC_W-1:0]          exc_pc,
    output logic                     rb_busy,
    output logic                     rst_we,
    output logic [$clog2(REG_N)-1:0] rst_reg,
    output logic [XLEN-1:0]          rst_val
);
    localparam int RA_W  = $clog2(REG_N);
    localparam int ENT_W = PC_W + RA_W + XLEN;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [ENT_W-1:0] newest;
    logic [CNT_W-1:0] count;
    logic             full, empty;
    logic             exc_take, push, pop_old, fire, drop;
    logic [PC_W-1:0]  newest_pc;

    // Gate pipeline-side requests against stall, rollback and exception.
    always_comb begin
        exc_take  = exc_req && !rb_busy;
        wr_stall  = full || rb_busy;
        push      = wr_en && !wr_stall && !exc_take && (wr_reg != '0);
        pop_old   = commit_en && !rb_busy && !exc_take && !empty;
        newest_pc = newest[ENT_W-1 -: PC_W];
        rst_we    = fire;
        rst_reg   = newest[XLEN +: RA_W];
        rst_val   = newest[XLEN-1:0];
    end

    hb_log_ring #(.DEPTH(DEPTH), .W(ENT_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({wr_pc, wr_reg, wr_old}),
        .pop_old   (pop_old),
        .pop_new   (fire),
        .clear     (drop),
        .newest    (newest),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    hb_rollback_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_req      (exc_take),
        .exc_pc       (exc_pc),
        .log_empty    (empty),
        .newest_pc    (newest_pc),
        .busy         (rb_busy),
        .restore_fire (fire),
        .drop_all     (drop)
    );

    p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !rb_busy) |=> rb_busy);
    p_stall_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rb_busy |-> wr_stall);
    p_log_empty_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_busy) |-> (count == '0));
    p_busy_no_new_record_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rb_busy |=> (count <= $past(count)));
endmodule

// File: tb/history_rollback_tb_top.sv
`timescale 1ns/1ps
module history_rollback_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, commit_en = 1'b0, exc_req = 1'b0;
    logic [31:0] wr_pc = '0, exc_pc = '0, wr_old = '0;
    logic [4:0]  wr_reg = '0;
    logic        wr_stall, rb_busy, rst_we;
    logic [4:0]  rst_reg;
    logic [31:0] rst_val;

    int checks = 0;
    int failures = 0;

    // Reference log, oldest record at index 0.
    logic [31:0] m_pc  [64];
    logic [4:0]  m_reg [64];
    logic [31:0] m_val [64];
    int          mcnt = 0;
    logic [31:0] gpc = 32'd100;

    always #2 clk = ~clk;

    history_rollback #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pc(wr_pc), .wr_reg(wr_reg),
        .wr_old(wr_old), .wr_stall(wr_stall), .commit_en(commit_en),
        .exc_req(exc_req), .exc_pc(exc_pc), .rb_busy(rb_busy), .rst_we(rst_we),
        .rst_reg(rst_reg), .rst_val(rst_val)
    );

    function automatic logic [31:0] oldv(input logic [4:0] r, input logic [31:0] p);
        return p * 32'd7 + {27'd0, r} + 32'h5A00_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus from a negedge to the next; model follows the rules.
    task automatic step(input bit we, input logic [4:0] rg, input bit cm, input bit ex, input logic [31:0] epc);
        bit was_full;
        was_full = (mcnt == DEPTH);
        chk(wr_stall == was_full, "R3 stall level", {31'd0, wr_stall}, {31'd0, was_full});
        wr_en = we; wr_reg = rg; wr_pc = gpc; wr_old = oldv(rg, gpc);
        commit_en = cm; exc_req = ex; exc_pc = epc;
        @(negedge clk);
        wr_en = 1'b0; commit_en = 1'b0; exc_req = 1'b0;
        if (!ex) begin
            if (cm && mcnt > 0) begin
                for (int i = 1; i < mcnt; i++) begin
                    m_pc[i-1] = m_pc[i]; m_reg[i-1] = m_reg[i]; m_val[i-1] = m_val[i];
                end
                mcnt--;
            end
            if (we && rg != 5'd0 && !was_full) begin
                m_pc[mcnt] = gpc; m_reg[mcnt] = rg; m_val[mcnt] = oldv(rg, gpc); mcnt++;
            end
        end
        if (we) gpc = gpc + 32'd4;
    endtask

    // Observe a rollback already accepted at the previous edge.
    task automatic walk(input logic [31:0] epc, input bit noise);
        chk(rb_busy == 1'b1, "R5 busy after exception", {31'd0, rb_busy}, 32'd1);
        while (mcnt > 0 && m_pc[mcnt-1] >= epc) begin
            chk(rst_we == 1'b1, "R6 restore enable", {31'd0, rst_we}, 32'd1);
            chk(rst_reg == m_reg[mcnt-1], "R6 restore register", {27'd0, rst_reg}, {27'd0, m_reg[mcnt-1]});
            chk(rst_val == m_val[mcnt-1], "R6 restore value", rst_val, m_val[mcnt-1]);
            chk(wr_stall == 1'b1, "R9 stall while busy", {31'd0, wr_stall}, 32'd1);
            if (noise) begin
                wr_en = 1'b1; wr_reg = 5'd9; commit_en = 1'b1; exc_req = 1'b1; exc_pc = 32'd0;
            end
            mcnt--;
            @(negedge clk);
        end
        chk(rst_we == 1'b0, "R8 final walk cycle no restore", {31'd0, rst_we}, 32'd0);
        chk(rb_busy == 1'b1, "R8 final walk cycle busy", {31'd0, rb_busy}, 32'd1);
        @(negedge clk);
        wr_en = 1'b0; commit_en = 1'b0; exc_req = 1'b0;
        chk(rb_busy == 1'b0, "R8 busy ends", {31'd0, rb_busy}, 32'd0);
        chk(wr_stall == 1'b0, "R7 log emptied", {31'd0, wr_stall}, 32'd0);
        mcnt = 0;
    endtask

    task automatic rollback(input logic [31:0] epc, input bit noise);
        step(1'b0, 5'd0, 1'b0, 1'b1, epc);
        walk(epc, noise);
    endtask

    initial begin
        logic [31:0] base;
        repeat (3) @(negedge clk);
        chk(rb_busy == 1'b0 && wr_stall == 1'b0 && rst_we == 1'b0, "R11 reset outputs",
            {29'd0, rb_busy, wr_stall, rst_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11/R7: empty log rolls back in one cycle.
        rollback(32'd0, 1'b0);
        // R1 R2 R7: partial rollback with a register 0 write in the middle.
        for (int i = 0; i < 5; i++) step(1'b1, (i == 2) ? 5'd0 : 5'(i + 1), 1'b0, 1'b0, 32'd0);
        rollback(m_pc[2], 1'b0);
        rollback(32'd0, 1'b0);   // R7: older records were dropped
        // R3 R4: fill, offer writes while full, commit, refill, restore all.
        for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 5'(i % 31 + 1), 1'b0, 1'b0, 32'd0);
        step(1'b0, 5'd0, 1'b1, 1'b0, 32'd0);
        step(1'b1, 5'd17, 1'b0, 1'b0, 32'd0);
        step(1'b1, 5'd18, 1'b1, 1'b0, 32'd0);
        rollback(32'd0, 1'b0);
        // R4: commit on empty log, then commits free oldest records.
        step(1'b0, 5'd0, 1'b1, 1'b0, 32'd0);
        for (int i = 0; i < 4; i++) step(1'b1, 5'(i + 20), 1'b0, 1'b0, 32'd0);
        step(1'b0, 5'd0, 1'b1, 1'b0, 32'd0);
        step(1'b0, 5'd0, 1'b1, 1'b0, 32'd0);
        rollback(32'd0, 1'b0);
        // R10: write and commit offered with the accepted exception.
        for (int i = 0; i < 3; i++) step(1'b1, 5'(i + 3), 1'b0, 1'b0, 32'd0);
        step(1'b1, 5'd30, 1'b1, 1'b1, 32'd0);
        walk(32'd0, 1'b0);
        // R9: writes, commits and exceptions during the walk.
        for (int i = 0; i < 4; i++) step(1'b1, 5'(i + 11), 1'b0, 1'b0, 32'd0);
        rollback(32'd0, 1'b1);
        rollback(32'd0, 1'b0);
        // R7 R8 sweep: fault position across every record and past the newest.
        for (int k = 0; k <= 6; k++) begin
            base = gpc;
            for (int i = 0; i < 6; i++) step(1'b1, 5'(i + k + 1), 1'b0, 1'b0, 32'd0);
            rollback(base + 32'(4 * k), 1'b0);
            rollback(32'd0, 1'b0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule